// File: doc/BRIEF.md
# Register-Memory DMA Engine

This block moves 32-bit words between a wave memory and a register space, or fills either one with zeros. Software starts a transfer by writing a control word. That word carries an execute flag, a zero-fill flag, a direction flag and a word count. The same write samples a memory base, given as a high field and a low field, and a register base, given as a word index. While a transfer runs, the engine drives a synchronous read/write port on each side. The read ports return data in the cycle after the request.

Each word operation is issued only in a cycle where the grant input is high. A copy reads from the source port in one cycle and writes the returned word to the destination port in the next cycle. When the last word is done, the execute flag clears and a one-cycle done event is produced for the interrupt logic of both processors.

Top module: `wave_reg_dma`

## Requirements
- R1: A transfer starts only on a cycle where `ctl_wr` and `ctl_exec` are both high while the engine is idle. `busy` and `exec_o` are high from the next cycle. A write with `ctl_exec` low starts nothing: no port activity and no `done`.
- R2: The memory start byte address is (`mem_base_hi` shifted left by 16) OR (`mem_base_lo` shifted left by 2), truncated to `MEM_AW` bits. Bits of the high field above the memory size have no effect.
- R3: The register start byte address is `reg_base` shifted left by 2. Both addresses advance by 4 for each word. Every address placed on either port is a multiple of 4.
- R4: With `ctl_zero`=1 and `ctl_to_mem`=1, the engine writes the value 0 to consecutive memory words.
- R5: With `ctl_zero`=1 and `ctl_to_mem`=0, the engine writes the value 0 to consecutive register words for the full requested count, whatever the memory base is.
- R6: With `ctl_zero`=0, `ctl_to_mem`=1 copies registers to memory, and `ctl_to_mem`=0 copies memory to registers, word for word.
- R7: In every mode that touches memory, the number of words moved is the smaller of `ctl_words` and (2^`MEM_AW` minus the start byte address) / 4.
- R8: On completion, `exec_o` and `busy` fall and `done` is high for exactly one cycle, in the same cycle that `busy` falls.
- R9: The engine issues one word per cycle in which `xfer_gnt` is high and none while it is low. With the grant held high, `done` appears N+1 cycles after the first busy cycle, where N is the number of words moved.
- R10: An effective count of zero completes without any port activity. `busy` is high for one cycle and then `done` fires.
- R11: Control writes that arrive while `busy` is high are ignored. The running transfer finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_exec | input | 1 | Execute flag of the control word |
| ctl_zero | input | 1 | Zero-fill flag |
| ctl_to_mem | input | 1 | Direction: 1 = toward memory, 0 = toward registers |
| ctl_words | input | LEN_W | Requested word count |
| mem_base_hi | input | HI_W | Memory base high field |
| mem_base_lo | input | LO_W | Memory base low field (word units) |
| reg_base | input | REG_AW-2 | Register base word index |
| xfer_gnt | input | 1 | Grant: a word may be issued this cycle |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after mem_rd |
| reg_addr | output | REG_AW | Register byte address |
| reg_rd | output | 1 | Register read request |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | DW | Register write data |
| reg_rdata | input | DW | Register read data, one cycle after reg_rd |
| exec_o | output | 1 | Execute flag readback, cleared at completion |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion event |

## Verification
The properties assume that reset is held low from time zero. They also assume that each read port returns its word exactly one cycle after the request, since the copy write leg takes whatever arrives in that cycle. The base fields and control fields are taken to matter only in the cycle of the starting write. The grant may change in any cycle.

The bench memory and register models answer every read on the following clock edge. The grant is either held high or driven pseudo-randomly on falling edges. Control fields change only on falling edges, and some of those changes fall deliberately inside a running transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

    // transfer kind, encoded as {zero, to_mem}
    typedef enum logic [1:0] {
        KIND_COPY_TO_REG = 2'b00,
        KIND_COPY_TO_MEM = 2'b01,
        KIND_ZERO_REG    = 2'b10,
        KIND_ZERO_MEM    = 2'b11
    } xfer_kind_e;

    function automatic xfer_kind_e kind_of(input logic zero, input logic to_mem);
        return xfer_kind_e'({zero, to_mem});
    endfunction

    function automatic logic kind_uses_mem(input xfer_kind_e k);
        return k != KIND_ZERO_REG;
    endfunction

    function automatic logic kind_is_copy(input xfer_kind_e k);
        return (k == KIND_COPY_TO_REG) || (k == KIND_COPY_TO_MEM);
    endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_pkg::*;
#(
    parameter int MEM_AW = 18,
    parameter int HI_W   = 8,
    parameter int LO_W   = 14,
    parameter int REG_AW = 15,
    parameter int LEN_W  = 15
) (
    input  logic [HI_W-1:0]   base_hi,
    input  logic [LO_W-1:0]   base_lo,
    input  logic [REG_AW-3:0] base_reg,
    input  logic [LEN_W-1:0]  words_req,
    input  xfer_kind_e        kind,
    output logic [MEM_AW-1:0] mem_start,
    output logic [REG_AW-1:0] reg_start,
    output logic [LEN_W-1:0]  words_eff
);
    localparam int FULL_W = HI_W + 16;
    localparam int CW     = (LEN_W > MEM_AW + 1) ? LEN_W : MEM_AW + 1;

    logic [FULL_W-1:0] joined;
    logic [MEM_AW:0]   room_bytes;
    logic [MEM_AW:0]   room_words;
    logic              clamp_hit;

    always_comb begin
        joined     = {base_hi, 16'h0000} | FULL_W'({base_lo, 2'b00});
        mem_start  = MEM_AW'(joined);
        reg_start  = {base_reg, 2'b00};
        room_bytes = {1'b1, {MEM_AW{1'b0}}} - {1'b0, mem_start};
        room_words = room_bytes >> 2;
        clamp_hit  = kind_uses_mem(kind) && (CW'(words_req) > CW'(room_words));
        words_eff  = clamp_hit ? LEN_W'(room_words) : words_req;
    end

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int MEM_AW = 18,
    parameter int REG_AW = 15,
    parameter int LEN_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_kind_e        kind_in,
    input  logic [LEN_W-1:0]  words_in,
    input  logic [MEM_AW-1:0] mem_start,
    input  logic [REG_AW-1:0] reg_start,
    input  logic              gnt,
    output logic              busy,
    output logic              exec_o,
    output logic              done,
    output logic              issue,
    output logic              pend,
    output xfer_kind_e        kind,
    output logic [MEM_AW-1:0] maddr,
    output logic [REG_AW-1:0] raddr,
    output logic [MEM_AW-1:0] maddr_prev,
    output logic [REG_AW-1:0] raddr_prev
);
    typedef struct packed {
        logic              run;
        logic              exec;
        logic              done;
        logic              pend;
        xfer_kind_e        kind;
        logic [LEN_W-1:0]  left;
        logic [MEM_AW-1:0] maddr;
        logic [REG_AW-1:0] raddr;
        logic [MEM_AW-1:0] maddr_prev;
        logic [REG_AW-1:0] raddr_prev;
    } state_t;

    state_t st_q, st_d;
    logic   issue_c;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        issue_c   = st_q.run && gnt && (st_q.left != '0);
        if (!st_q.run) begin
            if (start) begin
                st_d.run   = 1'b1;
                st_d.exec  = 1'b1;
                st_d.pend  = 1'b0;
                st_d.kind  = kind_in;
                st_d.left  = words_in;
                st_d.maddr = mem_start;
                st_d.raddr = reg_start;
            end
        end else begin
            st_d.pend = issue_c && kind_is_copy(st_q.kind);
            if (issue_c) begin
                st_d.left       = st_q.left - LEN_W'(1);
                st_d.maddr      = st_q.maddr + MEM_AW'(4);
                st_d.raddr      = st_q.raddr + REG_AW'(4);
                st_d.maddr_prev = st_q.maddr;
                st_d.raddr_prev = st_q.raddr;
            end
            if (st_q.left == '0) begin
                st_d.run  = 1'b0;
                st_d.exec = 1'b0;
                st_d.done = 1'b1;
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.run;
    assign exec_o     = st_q.exec;
    assign done       = st_q.done;
    assign issue      = issue_c;
    assign pend       = st_q.pend;
    assign kind       = st_q.kind;
    assign maddr      = st_q.maddr;
    assign raddr      = st_q.raddr;
    assign maddr_prev = st_q.maddr_prev;
    assign raddr_prev = st_q.raddr_prev;

endmodule

// File: rtl/dma_port_mux.sv
module dma_port_mux
    import dma_pkg::*;
#(
    parameter int DW     = 32,
    parameter int MEM_AW = 18,
    parameter int REG_AW = 15
) (
    input  xfer_kind_e        kind,
    input  logic              issue,
    input  logic              pend,
    input  logic [MEM_AW-1:0] maddr,
    input  logic [REG_AW-1:0] raddr,
    input  logic [MEM_AW-1:0] maddr_prev,
    input  logic [REG_AW-1:0] raddr_prev,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [DW-1:0]     reg_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_wdata,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DW-1:0]     reg_wdata
);
    always_comb begin
        mem_addr  = maddr;
        reg_addr  = raddr;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        mem_wdata = '0;
        reg_wdata = '0;
        unique case (kind)
            KIND_ZERO_MEM: mem_wr = issue;
            KIND_ZERO_REG: reg_wr = issue;
            KIND_COPY_TO_MEM: begin
                reg_rd    = issue;
                mem_wr    = pend;
                mem_addr  = maddr_prev;
                mem_wdata = reg_rdata;
            end
            KIND_COPY_TO_REG: begin
                mem_rd    = issue;
                reg_wr    = pend;
                reg_addr  = raddr_prev;
                reg_wdata = mem_rdata;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wave_reg_dma.sv
module wave_reg_dma
    import dma_pkg::*;
#(
    parameter int DW     = 32,
    parameter int MEM_AW = 18,
    parameter int HI_W   = 8,
    parameter int LO_W   = 14,
    parameter int REG_AW = 15,
    parameter int LEN_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_exec,
    input  logic              ctl_zero,
    input  logic              ctl_to_mem,
    input  logic [LEN_W-1:0]  ctl_words,
    input  logic [HI_W-1:0]   mem_base_hi,
    input  logic [LO_W-1:0]   mem_base_lo,
    input  logic [REG_AW-3:0] reg_base,
    input  logic              xfer_gnt,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DW-1:0]     reg_wdata,
    input  logic [DW-1:0]     reg_rdata,
    output logic              exec_o,
    output logic              busy,
    output logic              done
);
    xfer_kind_e        req_kind;
    xfer_kind_e        run_kind;
    logic [MEM_AW-1:0] mem_start;
    logic [REG_AW-1:0] reg_start;
    logic [LEN_W-1:0]  words_eff;
    logic              issue;
    logic              pend;
    logic [MEM_AW-1:0] maddr;
    logic [REG_AW-1:0] raddr;
    logic [MEM_AW-1:0] maddr_prev;
    logic [REG_AW-1:0] raddr_prev;
    logic              start;

    assign req_kind = kind_of(ctl_zero, ctl_to_mem);
    assign start    = ctl_wr && ctl_exec;

    dma_addr_gen #(
        .MEM_AW(MEM_AW), .HI_W(HI_W), .LO_W(LO_W), .REG_AW(REG_AW), .LEN_W(LEN_W)
    ) u_addr (
        .base_hi   (mem_base_hi),
        .base_lo   (mem_base_lo),
        .base_reg  (reg_base),
        .words_req (ctl_words),
        .kind      (req_kind),
        .mem_start (mem_start),
        .reg_start (reg_start),
        .words_eff (words_eff)
    );

    dma_ctrl #(
        .MEM_AW(MEM_AW), .REG_AW(REG_AW), .LEN_W(LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .kind_in    (req_kind),
        .words_in   (words_eff),
        .mem_start  (mem_start),
        .reg_start  (reg_start),
        .gnt        (xfer_gnt),
        .busy       (busy),
        .exec_o     (exec_o),
        .done       (done),
        .issue      (issue),
        .pend       (pend),
        .kind       (run_kind),
        .maddr      (maddr),
        .raddr      (raddr),
        .maddr_prev (maddr_prev),
        .raddr_prev (raddr_prev)
    );

    dma_port_mux #(
        .DW(DW), .MEM_AW(MEM_AW), .REG_AW(REG_AW)
    ) u_mux (
        .kind       (run_kind),
        .issue      (issue),
        .pend       (pend),
        .maddr      (maddr),
        .raddr      (raddr),
        .maddr_prev (maddr_prev),
        .raddr_prev (raddr_prev),
        .mem_rdata  (mem_rdata),
        .reg_rdata  (reg_rdata),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .reg_addr   (reg_addr),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata)
    );

endmodule

// File: rtl/dma_chk.sv
module dma_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic       ctl_exec,
    input logic       xfer_gnt,
    input logic       busy,
    input logic       exec_o,
    input logic       done,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [1:0] mem_lsb,
    input logic [1:0] reg_lsb
);
    // R1
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_wr && ctl_exec));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr || reg_rd || reg_wr));

    // R2
    mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_lsb == 2'b00));

    // R3
    reg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> (reg_lsb == 2'b00));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !exec_o && $past(busy)));

    // R8
    end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    read_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || reg_rd) |-> xfer_gnt);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr) |=> (busy || done));

endmodule

bind wave_reg_dma dma_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_exec (ctl_exec),
    .xfer_gnt (xfer_gnt),
    .busy     (busy),
    .exec_o   (exec_o),
    .done     (done),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .mem_lsb  (mem_addr[1:0]),
    .reg_lsb  (reg_addr[1:0])
);

// File: tb/sim_wave_reg_dma.sv
`timescale 1ns/1ps
module sim_wave_reg_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_exec = 1'b0, ctl_zero = 1'b0, ctl_to_mem = 1'b0;
    logic [14:0] ctl_words = '0;
    logic [7:0]  mem_base_hi = '0;
    logic [13:0] mem_base_lo = '0;
    logic [12:0] reg_base = '0;
    logic        xfer_gnt = 1'b1;
    logic [17:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [14:0] reg_addr;
    logic        reg_rd, reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;
    logic        exec_o, busy, done;

    int n_checks = 0;
    int n_errors = 0;
    int wr_count = 0;
    int rd_count = 0;
    bit full_gnt = 1'b1;

    logic [31:0] act_mem [bit [31:0]];
    logic [31:0] act_reg [bit [31:0]];
    logic [31:0] exp_mem [bit [31:0]];
    logic [31:0] exp_reg [bit [31:0]];

    wave_reg_dma u0 (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] mem_seed(input bit [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h13572468;
    endfunction
    function automatic logic [31:0] reg_seed(input bit [31:0] a);
        return (a * 32'h85EBCA6B) ^ 32'hA5A50000;
    endfunction
    function automatic logic [31:0] act_mem_rd(input bit [31:0] a);
        return act_mem.exists(a) ? act_mem[a] : mem_seed(a);
    endfunction
    function automatic logic [31:0] act_reg_rd(input bit [31:0] a);
        return act_reg.exists(a) ? act_reg[a] : reg_seed(a);
    endfunction
    function automatic logic [31:0] exp_mem_rd(input bit [31:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : mem_seed(a);
    endfunction
    function automatic logic [31:0] exp_reg_rd(input bit [31:0] a);
        return exp_reg.exists(a) ? exp_reg[a] : reg_seed(a);
    endfunction

    // memory and register space models: read data one cycle after request
    always @(posedge clk) begin
        if (mem_rd) begin mem_rdata <= act_mem_rd(32'(mem_addr)); rd_count++; end
        if (reg_rd) begin reg_rdata <= act_reg_rd(32'(reg_addr)); rd_count++; end
        if (mem_wr) begin act_mem[32'(mem_addr)] = mem_wdata; wr_count++; end
        if (reg_wr) begin act_reg[32'(reg_addr)] = reg_wdata; wr_count++; end
    end

    always @(negedge clk) xfer_gnt <= full_gnt ? 1'b1 : (($urandom % 10) < 7);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // apply the requirements to the expected arrays; returns words moved
    function automatic int model_xfer(input bit zero, input bit to_mem, input int len,
                                      input int hi, input int lo, input int rw);
        int ma = ((hi << 16) | (lo << 2)) & 32'h3FFFF;     // R2
        int ra = (rw << 2) & 32'h7FFF;                     // R3
        int room = (32'h40000 - ma) >> 2;                  // R7
        int eff = (!(zero && !to_mem) && len > room) ? room : len;
        for (int k = 0; k < eff; k++) begin
            bit [31:0] mk = 32'(ma + 4 * k);
            bit [31:0] rk = 32'((ra + 4 * k) & 32'h7FFF);
            if (zero && to_mem)       exp_mem[mk] = 32'h0;
            else if (zero)            exp_reg[rk] = 32'h0;
            else if (to_mem)          exp_mem[mk] = exp_reg_rd(rk);
            else                      exp_reg[rk] = exp_mem_rd(mk);
        end
        return eff;
    endfunction

    task automatic cmp_arrays(input string req);
        int bad = 0;
        bit [31:0] bk = 0;
        logic [31:0] ba = 0, be = 0;
        foreach (exp_mem[k]) if (act_mem_rd(k) !== exp_mem[k]) begin
            if (bad == 0) begin bk = k; ba = act_mem_rd(k); be = exp_mem[k]; end
            bad++;
        end
        if (act_mem.num() != exp_mem.num()) bad++;
        chk(bad == 0, req, $sformatf("memory contents (addr %0h)", bk), int'(ba), int'(be));
        bad = 0;
        foreach (exp_reg[k]) if (act_reg_rd(k) !== exp_reg[k]) begin
            if (bad == 0) begin bk = k; ba = act_reg_rd(k); be = exp_reg[k]; end
            bad++;
        end
        if (act_reg.num() != exp_reg.num()) bad++;
        chk(bad == 0, req, $sformatf("register contents (addr %0h)", bk), int'(ba), int'(be));
    endtask

    task automatic run_xfer(input bit zero, input bit to_mem, input int len, input int hi,
                            input int lo, input int rw, input bit full, input bit intrude,
                            input string req);
        int eff;
        int cyc = 0;
        eff = model_xfer(zero, to_mem, len, hi, lo, rw);
        full_gnt = full;
        @(negedge clk);
        wr_count = 0;
        ctl_wr = 1; ctl_exec = 1; ctl_zero = zero; ctl_to_mem = to_mem;
        ctl_words = 15'(len); mem_base_hi = 8'(hi); mem_base_lo = 14'(lo); reg_base = 13'(rw);
        @(negedge clk);
        ctl_wr = 0;
        chk(busy && exec_o, "R1", "busy/exec after start", int'(busy), 1);
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (intrude && cyc == 3) begin   // R11: control write while busy
                ctl_wr = 1; ctl_exec = 1; ctl_zero = ~zero; ctl_to_mem = ~to_mem;
                ctl_words = 15'd3; mem_base_lo = 14'(lo + 64); reg_base = 13'(rw + 40);
            end
            if (intrude && cyc == 4) ctl_wr = 0;
        end
        chk(done, "R8", "done observed", int'(done), 1);
        chk(!busy && !exec_o, "R8", "busy/exec after done", int'(busy) + int'(exec_o), 0);
        if (full)
            chk(cyc == eff + 1, (eff == 0) ? "R10" : "R9", "cycles to done", cyc, eff + 1);
        chk(wr_count == eff, req, "words written", wr_count, eff);
        cmp_arrays(req);
        @(negedge clk);
        chk(!done, "R8", "done width", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL R9 watchdog: actual %0d cycles expected fewer", 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk(!busy && !exec_o && !done && !mem_wr && !reg_wr, "R8", "reset state",
            int'(busy) + int'(exec_o) + int'(done), 0);
        rst_n = 1;
        @(negedge clk);

        // R1: write with execute clear starts nothing
        wr_count = 0; rd_count = 0;
        ctl_wr = 1; ctl_exec = 0; ctl_words = 15'd5;
        @(negedge clk);
        ctl_wr = 0;
        repeat (3) begin
            chk(!busy && !done, "R1", "no start without execute", int'(busy) + int'(done), 0);
            @(negedge clk);
        end
        chk(wr_count + rd_count == 0, "R1", "no port activity", wr_count + rd_count, 0);

        run_xfer(0, 0, 5, 1, 16'h10, 13'h20, 1, 0, "R6");      // memory -> registers
        run_xfer(0, 1, 6, 2, 16'h100, 13'h30, 1, 0, "R6");     // registers -> memory
        run_xfer(1, 1, 4, 0, 16'h40, 13'h0, 1, 0, "R4");       // zero memory
        run_xfer(1, 0, 7, 3, 14'h3FFF, 13'h50, 1, 0, "R5");    // zero registers, no clamp
        run_xfer(0, 0, 9, 3, 14'h3FFE, 13'h60, 1, 0, "R7");    // clamp to 2 words
        run_xfer(1, 1, 4, 8'h7, 14'h3FFF, 13'h0, 1, 0, "R2");  // high bits masked, 1 word
        run_xfer(0, 1, 12, 8'hF1, 14'h0, 13'h1FFC, 1, 0, "R3"); // register address wraps
        run_xfer(0, 0, 0, 0, 0, 0, 1, 0, "R10");              // zero count
        run_xfer(0, 0, 20, 1, 14'h200, 13'h100, 1, 1, "R11"); // intrusion while busy

        for (int i = 0; i < 25; i++) begin
            run_xfer(1'($urandom), 1'($urandom), int'($urandom % 41),
                     int'($urandom % 256), int'($urandom % 16384), int'($urandom % 8192),
                     1'b0, 1'($urandom % 4 == 0), "R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule